// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block gathers six interrupt sources for a small processor core and decides which one to present to it. The sources are two external request pins, three timer overflow pulses and one combined serial request line. Software sets a global enable, one enable bit per source and one priority bit per source (0 = low level, 1 = high level) through a small write port. The controller tracks which priority levels are currently being serviced. It offers a new request only at a machine-cycle boundary that is also the last cycle of an instruction.

When a request wins, the controller raises `irq` and holds a fixed vector address until the core pulses `ack`. At that acknowledge the winning level enters the in-service state, and the flag of the source is cleared when that source is one that clears in hardware. A `reti` pulse ends the most recent handler. An interrupted low-level handler therefore becomes current again after a high-level handler ends.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset `irq` is 0, `vec` is 0, `in_svc` is 0, and all enables, priorities and edge modes are 0.
- R2: A source is offered only if the global enable (write select 0, bit 6) is 1 and its own enable (write select 0, bit = source index) is 1. Source indices are: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 timer 2.
- R3: The vector is 16'h0003 + 8 × source index, which gives 0003, 000B, 0013, 001B, 0023 and 002B.
- R4: Among requests of one level, the lowest source index wins.
- R5: A high-level request (write select 1, bit = index, 1 = high) beats any low-level one. It may be taken while only a low-level handler is in service. A request whose level is already in service, or is below a level in service, waits.
- R6: With edge mode selected (write select 2, bit 0 for external 0, bit 1 for external 1), the pin is sampled on each `mc_stb`. A sample of 1 followed by a sample of 0 sets a latched flag, and that flag is cleared at acknowledge.
- R7: In level mode the request is the inverse of the last sampled pin value. It returns after acknowledge while the pin stays low.
- R8: Acknowledge clears the timer 0 and timer 1 flags. The timer 2 flag and the serial request are not cleared by acknowledge. Writing select 3 with a 1 at a source index clears that source's latched flag.
- R9: A new request is offered only in a cycle with `mc_stb` and `instr_end` both 1. It is not offered in a cycle that also carries `reti` or a write to select 0 or select 1.
- R10: `reti` clears the highest level set in `in_svc` (bit 1 = high level, bit 0 = low level).
- R11: Once raised, `irq` stays 1 with an unchanged `vec` until `ack`. At `ack` it drops and the level of the offered source is set in `in_svc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mc_stb | input | 1 | Machine-cycle strobe |
| instr_end | input | 1 | Current cycle is the last cycle of an instruction |
| reti | input | 1 | Return-from-interrupt pulse |
| ext_n | input | 2 | External request pins, active low |
| tmr_ovf | input | 3 | Overflow pulses of timers 0, 1, 2 |
| ser_req | input | 1 | Combined serial request level |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 enables, 1 priorities, 2 edge modes, 3 flag clear |
| wr_data | input | 7 | Write data |
| ack | input | 1 | Core acknowledge of the offered request |
| irq | output | 1 | Interrupt request to the core |
| vec | output | 16 | Vector address of the offered source |
| in_svc | output | 2 | Levels in service, bit 1 high, bit 0 low |

## Verification
A timer pulse sets its flag at the next edge, and `irq` follows one edge later, so it is sampled two cycles after the pulse. An edge-mode pin needs one edge to latch the flag and one more to raise `irq`. A level-mode pin needs one edge for the sample and one for the decision. `ack` and `reti` act on `irq` and `in_svc` at the edge that samples them. A `reti` or priority write also blocks that edge's decision, so the bench checks `irq` still 0 exactly one cycle after such a pulse and 1 in the cycle after that. All inputs are driven and all outputs sampled at the falling edge, so each check lands in the cycle it targets.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NSRC     = 6;
    localparam int NEXT     = 2;
    localparam int NTMR     = 3;
    localparam int NLVL     = 2;
    localparam int SRC_W    = $clog2(NSRC);
    localparam int LVL_W    = $clog2(NLVL);
    localparam int WR_W     = NSRC + 1;
    localparam int VEC_W    = 16;
    localparam int VEC_BASE = 3;
    localparam int VEC_STEP = 8;
    localparam int SER_IDX  = 4;
    localparam logic [NTMR-1:0] TMR_ACK_CLR = 3'b011;

    typedef enum logic [1:0] {
        SEL_EN   = 2'd0,
        SEL_PRIO = 2'd1,
        SEL_MODE = 2'd2,
        SEL_CLR  = 2'd3
    } wsel_e;

    function automatic logic [SRC_W-1:0] ext_src(input int k);
        return SRC_W'(2 * k);
    endfunction

    function automatic logic [SRC_W-1:0] tmr_src(input int k);
        return SRC_W'(2 * k + 1);
    endfunction

    function automatic logic [VEC_W-1:0] vec_of(input logic [SRC_W-1:0] idx);
        return VEC_W'(VEC_BASE) + VEC_W'(idx) * VEC_W'(VEC_STEP);
    endfunction
endpackage

// File: rtl/irqc_req_latch.sv
module irqc_req_latch
    import irqc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mc_stb,
    input  logic [NEXT-1:0] ext_n,
    input  logic [NEXT-1:0] edge_mode,
    input  logic [NEXT-1:0] ext_clr,
    input  logic [NTMR-1:0] tmr_ovf,
    input  logic [NTMR-1:0] tmr_clr,
    input  logic            ser_req,
    output logic [NSRC-1:0] req
);
    typedef struct packed {
        logic [NEXT-1:0] smp;
        logic [NEXT-1:0] eflag;
        logic [NTMR-1:0] tflag;
    } lat_t;

    lat_t lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        for (int k = 0; k < NEXT; k++) begin
            if (mc_stb) lat_d.smp[k] = ext_n[k];
            if (ext_clr[k]) lat_d.eflag[k] = 1'b0;
            if (mc_stb && edge_mode[k] && lat_q.smp[k] && !ext_n[k])
                lat_d.eflag[k] = 1'b1;
        end
        for (int k = 0; k < NTMR; k++) begin
            if (tmr_clr[k]) lat_d.tflag[k] = 1'b0;
            if (tmr_ovf[k]) lat_d.tflag[k] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q.smp   <= '1;
            lat_q.eflag <= '0;
            lat_q.tflag <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

    for (genvar k = 0; k < NEXT; k++) begin : g_ext
        assign req[2*k] = edge_mode[k] ? lat_q.eflag[k] : !lat_q.smp[k];
    end
    for (genvar k = 0; k < NTMR; k++) begin : g_tmr
        assign req[2*k+1] = lat_q.tflag[k];
    end
    assign req[SER_IDX] = ser_req;
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick
    import irqc_pkg::*;
(
    input  logic [NSRC-1:0]  req,
    input  logic [NSRC-1:0]  en,
    input  logic [NSRC-1:0]  prio,
    input  logic             gen,
    input  logic [NLVL-1:0]  svc,
    output logic             hit,
    output logic [SRC_W-1:0] src,
    output logic [LVL_W-1:0] lvl
);
    logic [NLVL-1:0]       lv_hit;
    logic [NLVL*SRC_W-1:0] lv_src;

    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
        logic [NSRC-1:0]  mask;
        logic             open;
        logic             any;
        logic [SRC_W-1:0] first;

        if (g == 0) begin : g_lo
            assign mask = req & en & ~prio & {NSRC{gen}};
        end else begin : g_hi
            assign mask = req & en & prio & {NSRC{gen}};
        end
        assign open = ~|svc[NLVL-1:g];

        always_comb begin
            any   = 1'b0;
            first = '0;
            for (int i = NSRC - 1; i >= 0; i--) begin
                if (mask[i]) begin
                    any   = 1'b1;
                    first = SRC_W'(i);
                end
            end
        end

        assign lv_hit[g] = any && open;
        assign lv_src[g*SRC_W +: SRC_W] = first;
    end

    always_comb begin
        hit = 1'b0;
        src = '0;
        lvl = '0;
        for (int g = 0; g < NLVL; g++) begin
            if (lv_hit[g]) begin
                hit = 1'b1;
                src = lv_src[g*SRC_W +: SRC_W];
                lvl = LVL_W'(g);
            end
        end
    end
endmodule

// File: rtl/irqc_svc_stack.sv
module irqc_svc_stack
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [LVL_W-1:0] push_lvl,
    input  logic             pop,
    output logic [NLVL-1:0]  svc
);
    logic [NLVL-1:0] svc_d, svc_q;

    always_comb begin
        logic found;
        svc_d = svc_q;
        found = 1'b0;
        if (push) begin
            svc_d[push_lvl] = 1'b1;
        end else if (pop) begin
            for (int g = NLVL - 1; g >= 0; g--) begin
                if (!found && svc_q[g]) begin
                    svc_d[g] = 1'b0;
                    found    = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) svc_q <= '0;
        else        svc_q <= svc_d;
    end

    assign svc = svc_q;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mc_stb,
    input  logic             instr_end,
    input  logic             reti,
    input  logic [NEXT-1:0]  ext_n,
    input  logic [NTMR-1:0]  tmr_ovf,
    input  logic             ser_req,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [WR_W-1:0]  wr_data,
    input  logic             ack,
    output logic             irq,
    output logic [VEC_W-1:0] vec,
    output logic [NLVL-1:0]  in_svc
);
    typedef struct packed {
        logic [NSRC-1:0]  en;
        logic             gen;
        logic [NSRC-1:0]  prio;
        logic [NEXT-1:0]  mode;
        logic             irq;
        logic [VEC_W-1:0] vec;
        logic [SRC_W-1:0] src;
        logic [LVL_W-1:0] lvl;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NSRC-1:0]  req;
    logic             hit;
    logic [SRC_W-1:0] pick_src;
    logic [LVL_W-1:0] pick_lvl;
    logic [NLVL-1:0]  svc;
    logic [NEXT-1:0]  ext_clr;
    logic [NTMR-1:0]  tmr_clr;
    logic             ack_now;
    logic             cfg_wr;
    logic             clr_wr;
    logic             take;
    logic             glb_en;

    assign ack_now = ctl_q.irq && ack;
    assign cfg_wr  = wr_en && (wr_sel == SEL_EN || wr_sel == SEL_PRIO);
    assign clr_wr  = wr_en && (wr_sel == SEL_CLR);
    assign take    = mc_stb && instr_end && !reti && !cfg_wr && !ctl_q.irq && hit;
    assign glb_en  = ctl_q.gen;

    for (genvar k = 0; k < NEXT; k++) begin : g_eclr
        assign ext_clr[k] = (clr_wr && wr_data[2*k])
                          || (ack_now && ctl_q.src == ext_src(k));
    end
    for (genvar k = 0; k < NTMR; k++) begin : g_tclr
        assign tmr_clr[k] = (clr_wr && wr_data[2*k+1])
                          || (ack_now && TMR_ACK_CLR[k] && ctl_q.src == tmr_src(k));
    end

    irqc_req_latch u_lat (
        .clk       (clk),
        .rst_n     (rst_n),
        .mc_stb    (mc_stb),
        .ext_n     (ext_n),
        .edge_mode (ctl_q.mode),
        .ext_clr   (ext_clr),
        .tmr_ovf   (tmr_ovf),
        .tmr_clr   (tmr_clr),
        .ser_req   (ser_req),
        .req       (req)
    );

    irqc_pick u_pick (
        .req  (req),
        .en   (ctl_q.en),
        .prio (ctl_q.prio),
        .gen  (ctl_q.gen),
        .svc  (svc),
        .hit  (hit),
        .src  (pick_src),
        .lvl  (pick_lvl)
    );

    irqc_svc_stack u_stk (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (ack_now),
        .push_lvl (ctl_q.lvl),
        .pop      (reti),
        .svc      (svc)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (take) begin
            ctl_d.irq = 1'b1;
            ctl_d.vec = vec_of(pick_src);
            ctl_d.src = pick_src;
            ctl_d.lvl = pick_lvl;
        end
        if (ack_now) ctl_d.irq = 1'b0;
        if (wr_en) begin
            unique case (wsel_e'(wr_sel))
                SEL_EN: begin
                    ctl_d.en  = wr_data[NSRC-1:0];
                    ctl_d.gen = wr_data[NSRC];
                end
                SEL_PRIO: ctl_d.prio = wr_data[NSRC-1:0];
                SEL_MODE: ctl_d.mode = wr_data[NEXT-1:0];
                SEL_CLR:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign irq    = ctl_q.irq;
    assign vec    = ctl_q.vec;
    assign in_svc = svc;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             mc_stb,
    input logic             instr_end,
    input logic             reti,
    input logic             ack,
    input logic             irq,
    input logic [VEC_W-1:0] vec,
    input logic [NLVL-1:0]  in_svc,
    input logic             gen
);
    a_r11_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !ack |=> irq && $stable(vec));

    a_r11_ack_enters_svc: assert property (@(posedge clk) disable iff (!rst_n)
        irq && ack |=> !irq && in_svc != '0);

    a_r9_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
        !irq && !(mc_stb && instr_end) |=> !irq);

    a_r9_reti_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !irq && reti |=> !irq);

    a_r2_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(gen));

    a_r3_vector_shape: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> vec[2:0] == 3'd3 && vec < VEC_W'(VEC_BASE + VEC_STEP * NSRC));

    a_r10_pop_high: assert property (@(posedge clk) disable iff (!rst_n)
        reti && !(irq && ack) && in_svc[1] |=> !in_svc[1] && in_svc[0] == $past(in_svc[0]));
endmodule

bind irq_prio_ctrl irqc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mc_stb    (mc_stb),
    .instr_end (instr_end),
    .reti      (reti),
    .ack       (ack),
    .irq       (irq),
    .vec       (vec),
    .in_svc    (in_svc),
    .gen       (glb_en)
);

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        mc_stb, instr_end, reti, ser_req, wr_en, ack;
    logic [1:0]  ext_n;
    logic [2:0]  tmr_ovf;
    logic [1:0]  wr_sel;
    logic [6:0]  wr_data;
    logic        irq;
    logic [15:0] vec;
    logic [1:0]  in_svc;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irq_prio_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .mc_stb(mc_stb), .instr_end(instr_end),
        .reti(reti), .ext_n(ext_n), .tmr_ovf(tmr_ovf), .ser_req(ser_req),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .ack(ack),
        .irq(irq), .vec(vec), .in_svc(in_svc)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; mc_stb = 1'b1; instr_end = 1'b1; reti = 1'b0;
        ser_req = 1'b0; wr_en = 1'b0; ack = 1'b0; ext_n = 2'b11;
        tmr_ovf = 3'b000; wr_sel = 2'd0; wr_data = '0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [6:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic pulse_t(input logic [2:0] m);
        tmr_ovf = m;
        tick(1);
        tmr_ovf = 3'b000;
    endtask

    task automatic do_ack();
        ack = 1'b1; tick(1); ack = 1'b0;
    endtask

    task automatic do_reti();
        reti = 1'b1; tick(1); reti = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 irq", irq, 0);
        chk("R1 vec", vec, 0);
        chk("R1 in_svc", in_svc, 0);
        pulse_t(3'b111); tick(3);
        chk("R1 enables cleared", irq, 0);
    endtask

    task automatic t_gating();
        do_reset();
        pulse_t(3'b001); tick(3);
        chk("R2 no enables", irq, 0);
        wr(2'd0, 7'h02); tick(3);
        chk("R2 no global", irq, 0);
        wr(2'd0, 7'h42); tick(2);
        chk("R2 enabled irq", irq, 1);
        chk("R3 timer0 vec", vec, 16'h000B);
        do_ack();
        chk("R11 ack drops irq", irq, 0);
        chk("R11 low in service", in_svc, 2'b01);
        do_reti(); tick(3);
        chk("R10 pop low", in_svc, 2'b00);
        chk("R8 timer0 cleared on ack", irq, 0);
    endtask

    task automatic t_order();
        do_reset();
        wr(2'd0, 7'h7F);
        pulse_t(3'b111); tick(2);
        chk("R4 first timer0", vec, 16'h000B);
        do_ack(); do_reti(); tick(2);
        chk("R4 second timer1", vec, 16'h001B);
        do_ack(); do_reti(); tick(2);
        chk("R4 third timer2", vec, 16'h002B);
        do_ack(); do_reti(); tick(2);
        chk("R8 timer2 kept after ack", irq, 1);
        chk("R8 timer2 vec", vec, 16'h002B);
        do_ack();
        wr(2'd3, 7'h20);
        do_reti(); tick(3);
        chk("R8 timer2 software clear", irq, 0);
    endtask

    task automatic t_hold();
        do_reset();
        wr(2'd0, 7'h7F);
        pulse_t(3'b010); tick(2);
        chk("R3 timer1 vec", vec, 16'h001B);
        pulse_t(3'b001); tick(2);
        chk("R11 vec stable while pending", vec, 16'h001B);
        chk("R11 irq stays", irq, 1);
        do_ack(); do_reti(); tick(2);
        chk("R4 timer0 after", vec, 16'h000B);
    endtask

    task automatic t_preempt();
        do_reset();
        wr(2'd0, 7'h7F);
        wr(2'd1, 7'h20);
        pulse_t(3'b101); tick(2);
        chk("R5 high beats order", vec, 16'h002B);
        do_ack();
        chk("R5 high in service", in_svc, 2'b10);
        wr(2'd3, 7'h20);
        do_reti(); tick(2);
        chk("R5 low after high", vec, 16'h000B);
        do_ack();
        chk("R5 low in service", in_svc, 2'b01);
        pulse_t(3'b010); tick(3);
        chk("R5 same level waits", irq, 0);
        pulse_t(3'b100); tick(2);
        chk("R5 preempt irq", irq, 1);
        chk("R5 preempt vec", vec, 16'h002B);
        do_ack();
        chk("R5 nested", in_svc, 2'b11);
        wr(2'd3, 7'h20);
        do_reti();
        chk("R10 pop most recent", in_svc, 2'b01);
        tick(3);
        chk("R5 low still blocked", irq, 0);
        do_reti(); tick(2);
        chk("R10 pop to empty", in_svc, 2'b00);
        chk("R5 waiting one offered", vec, 16'h001B);
    endtask

    task automatic t_edge();
        do_reset();
        wr(2'd2, 7'h01);
        wr(2'd0, 7'h41);
        ext_n[0] = 1'b0;
        tick(1);
        chk("R6 flag not yet offered", irq, 0);
        tick(1);
        chk("R6 edge irq", irq, 1);
        chk("R3 ext0 vec", vec, 16'h0003);
        do_ack(); do_reti(); tick(3);
        chk("R6 flag cleared, pin low", irq, 0);
        ext_n[0] = 1'b1; tick(1);
        ext_n[0] = 1'b0; tick(2);
        chk("R6 new edge", irq, 1);
    endtask

    task automatic t_level();
        do_reset();
        wr(2'd0, 7'h44);
        ext_n[1] = 1'b0; tick(2);
        chk("R7 level irq", irq, 1);
        chk("R3 ext1 vec", vec, 16'h0013);
        do_ack(); do_reti(); tick(2);
        chk("R7 reappears", irq, 1);
        do_ack();
        ext_n[1] = 1'b1; tick(1);
        do_reti(); tick(3);
        chk("R7 released", irq, 0);
    endtask

    task automatic t_serial();
        do_reset();
        wr(2'd0, 7'h50);
        ser_req = 1'b1; tick(2);
        chk("R3 serial vec", vec, 16'h0023);
        do_ack(); do_reti(); tick(2);
        chk("R8 serial not cleared", irq, 1);
        do_ack();
        ser_req = 1'b0;
        do_reti(); tick(3);
        chk("R8 serial gone", irq, 0);
    endtask

    task automatic t_postpone();
        do_reset();
        wr(2'd0, 7'h42);
        instr_end = 1'b0;
        pulse_t(3'b001); tick(3);
        chk("R9 mid instruction", irq, 0);
        instr_end = 1'b1; mc_stb = 1'b0; tick(3);
        chk("R9 no strobe", irq, 0);
        mc_stb = 1'b1; tick(1);
        chk("R9 boundary taken", irq, 1);
        do_ack(); do_reti(); tick(2);
        pulse_t(3'b001);
        wr(2'd1, 7'h00);
        chk("R9 prio write blocks", irq, 0);
        tick(1);
        chk("R9 next cycle taken", irq, 1);
        do_ack(); do_reti(); tick(2);
        pulse_t(3'b001);
        do_reti();
        chk("R9 reti blocks", irq, 0);
        tick(1);
        chk("R9 after reti taken", irq, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_gating();
        t_order();
        t_hold();
        t_preempt();
        t_edge();
        t_level();
        t_serial();
        t_postpone();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule